// File: doc/BRIEF.md
# Single-Precision Float to Fixed-Point Converter

This block turns one IEEE-754 binary32 operand into a two's-complement or unsigned fixed-point integer. The caller supplies a count of fractional bits, and the operand is multiplied by two raised to that count before the conversion to an integer. The integer part is kept and any fraction is dropped, which always rounds toward zero; no rounding-mode setting is consulted. The result is either 16 or 32 bits wide. It always leaves the block as a 32-bit word: a signed result is sign-extended and an unsigned result is zero-extended.

The conversion is combinational. Its result is captured in a register on the clock edge at which `in_valid` is high, so the result and its flags appear one cycle later. Values that the chosen format cannot hold saturate and raise an invalid flag. A NaN operand also raises the invalid flag. Dropping nonzero fraction bits raises an inexact flag.

A two-state machine tracks whether the output register holds a fresh result. In `ST_IDLE`, `out_valid` is low. In `ST_DONE`, `out_valid` is high. The machine has two transitions. Any state moves to `ST_DONE` when `in_valid` is high (`capture`), and to `ST_IDLE` when `in_valid` is low (`drain`). Reset forces `ST_IDLE`.

Top module: `fxc_cvt`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `out_valid`, `fx_out`, `flag_invalid` and `flag_inexact` are all 0.
- R2: The cycle after an edge with `in_valid` high, `out_valid` is 1 and the outputs hold the conversion of the inputs sampled at that edge. After an edge with `in_valid` low, `out_valid` is 0 and `fx_out` and both flags keep their previous values.
- R3: For a finite operand `x` and `frac_bits = k`, the result is the integer part of `x * 2^k`, truncated toward zero. The output width is selected by `half_sel`: 1 gives a 16-bit result and 0 gives a 32-bit result. `k` ranges from 0 to the selected width.
- R4: When `unsigned_sel` = 0, the result is two's complement. With `half_sel` = 1, bits 31..16 of `fx_out` equal bit 15.
- R5: When `unsigned_sel` = 1, the result is unsigned. With `half_sel` = 1, bits 31..16 of `fx_out` are 0.
- R6: A signed result whose truncated value is above 2^(N-1)-1 gives 0x00007FFF (N=16) or 0x7FFFFFFF (N=32). One below -2^(N-1) gives 0xFFFF8000 or 0x80000000. In both cases `flag_invalid` is 1, and infinities behave as these out-of-range values.
- R7: An unsigned result whose truncated value is above 2^N-1 gives 0x0000FFFF (N=16) or 0xFFFFFFFF (N=32), with `flag_invalid` set. A negative operand gives 0. For that negative operand, `flag_invalid` is set if its truncated value is nonzero; otherwise only `flag_inexact` may be set.
- R8: A NaN operand (exponent field bits 30..23 all ones, fraction bits 22..0 nonzero) gives 0 with `flag_invalid` = 1 and `flag_inexact` = 0.
- R9: `flag_inexact` is 1 exactly when the result is not invalid and nonzero fraction bits of `x * 2^k` were dropped. The two flags are never set together.
- R10: A subnormal operand (exponent field 0) is converted by its true value. For every allowed `k` it truncates to 0, with `flag_inexact` set when its fraction is nonzero and `flag_invalid` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture a conversion at this edge |
| fp_in | input | 32 | binary32 operand |
| frac_bits | input | 6 | Number of fractional bits, 0 to result width |
| unsigned_sel | input | 1 | 1 = unsigned result, 0 = signed |
| half_sel | input | 1 | 1 = 16-bit result, 0 = 32-bit result |
| out_valid | output | 1 | Outputs hold a fresh result |
| fx_out | output | 32 | Extended fixed-point result |
| flag_invalid | output | 1 | NaN or saturated result |
| flag_inexact | output | 1 | Nonzero fraction bits dropped |

## Verification
The sweep crosses every exponent near the integer boundaries with the smallest, largest, mid-range and alternating mantissas, both signs, both widths, both signednesses, and fraction counts of 0, 1, 5, N-1 and N.
- The exponents that move the binary point across the result range separate exact results from truncated ones, and in-range values from saturated ones.
- The exponent extremes reach subnormals, infinities and NaNs.
- Negative operands of magnitude below one tell the unsigned inexact-only case apart from the unsigned invalid case.
- The extreme fraction counts show whether the scale is applied at the correct bit position.

A directed step with `in_valid` low after a change of operand shows whether the result register holds its value. A reset issued after activity shows whether the outputs are cleared.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int FP_W    = 1 + EXP_W + MAN_W;
    localparam int SIG_W   = MAN_W + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int LSB_OFS = BIAS + MAN_W;
    localparam int SCL_W   = 11;

    typedef struct packed {
        logic                    sign;
        logic                    is_nan;
        logic                    is_inf;
        logic [SIG_W-1:0]        sig;
        logic signed [SCL_W-1:0] lsb_exp;
    } fp_fields_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } cvt_state_e;

endpackage

// File: rtl/fxc_unpack.sv
module fxc_unpack
    import fxc_pkg::*;
(
    input  logic [FP_W-1:0] fp,
    output fp_fields_t      fields
);

    logic [EXP_W-1:0] exp_f;
    logic [EXP_W-1:0] exp_eff;
    logic [MAN_W-1:0] man_f;

    always_comb begin
        exp_f          = fp[FP_W-2 -: EXP_W];
        man_f          = fp[MAN_W-1:0];
        exp_eff        = (exp_f == '0) ? EXP_W'(1) : exp_f;
        fields.sign    = fp[FP_W-1];
        fields.is_nan  = (exp_f == '1) && (man_f != '0);
        fields.is_inf  = (exp_f == '1) && (man_f == '0);
        fields.sig     = {(exp_f != '0), man_f};
        fields.lsb_exp = $signed({{(SCL_W-EXP_W){1'b0}}, exp_eff}) - $signed(SCL_W'(LSB_OFS));
    end

endmodule

// File: rtl/fxc_scale.sv
module fxc_scale
    import fxc_pkg::*;
#(
    parameter int OUT_W = 32,
    parameter int FB_W  = 6,
    localparam int MAG_W = OUT_W + 1
)(
    input  fp_fields_t       fields,
    input  logic [FB_W-1:0]  frac_bits,
    output logic [MAG_W-1:0] mag,
    output logic             huge,
    output logic             lost
);

    localparam int LSH_MAX = MAG_W - SIG_W;

    logic signed [SCL_W-1:0] shift;
    logic [SCL_W-1:0]        rsh;
    logic [2*SIG_W-1:0]      ext;

    always_comb begin
        shift = fields.lsb_exp + $signed({{(SCL_W-FB_W){1'b0}}, frac_bits});
        mag   = '0;
        huge  = 1'b0;
        lost  = 1'b0;
        rsh   = '0;
        ext   = '0;
        if (!shift[SCL_W-1]) begin
            if (shift > $signed(SCL_W'(LSH_MAX))) begin
                huge = |fields.sig;
            end else begin
                mag = MAG_W'(fields.sig) << shift;
            end
        end else begin
            rsh = -shift;
            if (rsh >= SCL_W'(SIG_W)) begin
                lost = |fields.sig;
            end else begin
                ext  = {fields.sig, {SIG_W{1'b0}}} >> rsh;
                mag  = MAG_W'(ext[2*SIG_W-1:SIG_W]);
                lost = |ext[SIG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fxc_limit.sv
module fxc_limit #(
    parameter int OUT_W  = 32,
    parameter int HALF_W = 16,
    localparam int MAG_W = OUT_W + 1
)(
    input  logic             sign,
    input  logic             is_nan,
    input  logic             is_inf,
    input  logic             huge,
    input  logic             lost,
    input  logic [MAG_W-1:0] mag,
    input  logic             unsigned_sel,
    input  logic             half_sel,
    output logic [OUT_W-1:0] value,
    output logic             invalid,
    output logic             inexact
);

    localparam logic [MAG_W-1:0] U_FULL = {1'b0, {OUT_W{1'b1}}};
    localparam logic [MAG_W-1:0] U_HALF = MAG_W'({HALF_W{1'b1}});
    localparam logic [MAG_W-1:0] P_FULL = MAG_W'({(OUT_W-1){1'b1}});
    localparam logic [MAG_W-1:0] P_HALF = MAG_W'({(HALF_W-1){1'b1}});
    localparam logic [MAG_W-1:0] N_FULL = MAG_W'(1) << (OUT_W - 1);
    localparam logic [MAG_W-1:0] N_HALF = MAG_W'(1) << (HALF_W - 1);
    localparam logic [OUT_W-1:0] MIN_FULL = OUT_W'(1) << (OUT_W - 1);
    localparam logic [OUT_W-1:0] MIN_HALF = {{(OUT_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

    logic [MAG_W-1:0] lim_u;
    logic [MAG_W-1:0] lim_p;
    logic [MAG_W-1:0] lim_n;
    logic [OUT_W-1:0] min_val;
    logic [MAG_W-1:0] neg_mag;
    logic             over;

    always_comb begin
        lim_u   = half_sel ? U_HALF : U_FULL;
        lim_p   = half_sel ? P_HALF : P_FULL;
        lim_n   = half_sel ? N_HALF : N_FULL;
        min_val = half_sel ? MIN_HALF : MIN_FULL;
        neg_mag = ~mag + MAG_W'(1);
        over    = is_inf | huge;
        value   = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        if (is_nan) begin
            invalid = 1'b1;
        end else if (unsigned_sel) begin
            if (sign) begin
                if (over || (mag != '0)) invalid = 1'b1;
                else                     inexact = lost;
            end else if (over || (mag > lim_u)) begin
                value   = lim_u[OUT_W-1:0];
                invalid = 1'b1;
            end else begin
                value   = mag[OUT_W-1:0];
                inexact = lost;
            end
        end else if (sign) begin
            if (over || (mag > lim_n)) begin
                value   = min_val;
                invalid = 1'b1;
            end else begin
                value   = neg_mag[OUT_W-1:0];
                inexact = lost;
            end
        end else begin
            if (over || (mag > lim_p)) begin
                value   = lim_p[OUT_W-1:0];
                invalid = 1'b1;
            end else begin
                value   = mag[OUT_W-1:0];
                inexact = lost;
            end
        end
    end

endmodule

// File: rtl/fxc_cvt.sv
module fxc_cvt
    import fxc_pkg::*;
#(
    parameter int OUT_W  = 32,
    parameter int HALF_W = 16,
    localparam int FB_W  = $clog2(OUT_W + 1),
    localparam int MAG_W = OUT_W + 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  fp_in,
    input  logic [FB_W-1:0]  frac_bits,
    input  logic             unsigned_sel,
    input  logic             half_sel,
    output logic             out_valid,
    output logic [OUT_W-1:0] fx_out,
    output logic             flag_invalid,
    output logic             flag_inexact
);

    cvt_state_e       state_q;
    cvt_state_e       state_d;
    fp_fields_t       fields;
    logic [MAG_W-1:0] mag;
    logic             huge;
    logic             lost;
    logic [OUT_W-1:0] conv_val;
    logic             conv_inv;
    logic             conv_inx;

    fxc_unpack u_unpack (
        .fp     (fp_in),
        .fields (fields)
    );

    fxc_scale #(.OUT_W(OUT_W), .FB_W(FB_W)) u_scale (
        .fields    (fields),
        .frac_bits (frac_bits),
        .mag       (mag),
        .huge      (huge),
        .lost      (lost)
    );

    fxc_limit #(.OUT_W(OUT_W), .HALF_W(HALF_W)) u_limit (
        .sign         (fields.sign),
        .is_nan       (fields.is_nan),
        .is_inf       (fields.is_inf),
        .huge         (huge),
        .lost         (lost),
        .mag          (mag),
        .unsigned_sel (unsigned_sel),
        .half_sel     (half_sel),
        .value        (conv_val),
        .invalid      (conv_inv),
        .inexact      (conv_inx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions: capture (in_valid) and drain (!in_valid)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // result register, loaded on capture
    always_ff @(posedge clk) begin
        if (rst) begin
            fx_out       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else if (in_valid) begin
            fx_out       <= conv_val;
            flag_invalid <= conv_inv;
            flag_inexact <= conv_inx;
        end
    end

    // state-decoded output
    always_comb begin
        out_valid = (state_q == ST_DONE);
    end

endmodule

// File: rtl/fxc_cvt_chk.sv
module fxc_cvt_chk #(
    parameter int OUT_W  = 32,
    parameter int HALF_W = 16
)(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [31:0]      fp_in,
    input logic             unsigned_sel,
    input logic             half_sel,
    input logic             out_valid,
    input logic [OUT_W-1:0] fx_out,
    input logic             flag_invalid,
    input logic             flag_inexact
);

    a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(fx_out) && $stable(flag_invalid) && $stable(flag_inexact)));

    a_r9_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(flag_invalid && flag_inexact));

    a_r5_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && unsigned_sel && half_sel) |=> (fx_out[OUT_W-1:HALF_W] == '0));

    a_r4_sign_ext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !unsigned_sel && half_sel)
        |=> (fx_out[OUT_W-1:HALF_W] == {(OUT_W-HALF_W){fx_out[HALF_W-1]}}));

    a_r8_nan: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (fp_in[30:23] == 8'hFF) && (fp_in[22:0] != '0))
        |=> ((fx_out == '0) && flag_invalid && !flag_inexact));

endmodule

bind fxc_cvt fxc_cvt_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .fp_in        (fp_in),
    .unsigned_sel (unsigned_sel),
    .half_sel     (half_sel),
    .out_valid    (out_valid),
    .fx_out       (fx_out),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact)
);

// File: tb/fxc_cvt_tb.sv
`timescale 1ns/1ps
module fxc_cvt_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] fp_in = '0;
    logic [5:0]  frac_bits = '0;
    logic        unsigned_sel = 1'b0;
    logic        half_sel = 1'b0;
    logic        out_valid;
    logic [31:0] fx_out;
    logic        flag_invalid;
    logic        flag_inexact;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fxc_cvt u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .fp_in        (fp_in),
        .frac_bits    (frac_bits),
        .unsigned_sel (unsigned_sel),
        .half_sel     (half_sel),
        .out_valid    (out_valid),
        .fx_out       (fx_out),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (op %h k %0d u %0b h %0b)",
                     tag, what, act, exp, fp_in, frac_bits, unsigned_sel, half_sel);
        end
    endtask

    // reference: real arithmetic on the decoded operand
    task automatic model(input logic [31:0] f, input int k, input bit uns, input bit half,
                         output logic [31:0] r, output bit inv, output bit inx);
        int     e;
        int     n;
        real    sig;
        real    scaled;
        real    hi;
        real    lo;
        longint q;
        e = int'(f[30:23]);
        n = half ? 16 : 32;
        r = '0; inv = 1'b0; inx = 1'b0;
        if (e == 255 && f[22:0] != '0) begin
            inv = 1'b1;
            return;
        end
        if (e == 255) begin
            scaled = f[31] ? -1.0e300 : 1.0e300;
        end else begin
            sig = (e == 0) ? real'(f[22:0]) : real'(f[22:0]) + 8388608.0;
            scaled = sig * (2.0 ** real'(((e == 0) ? 1 : e) - 150 + k));
            if (f[31]) scaled = -scaled;
        end
        hi = uns ? 2.0 ** real'(n) : 2.0 ** real'(n - 1);
        lo = uns ? -1.0 : -(2.0 ** real'(n - 1)) - 1.0;
        if (scaled >= hi) begin
            inv = 1'b1;
            r = uns ? (half ? 32'h0000FFFF : 32'hFFFFFFFF) : (half ? 32'h00007FFF : 32'h7FFFFFFF);
        end else if (scaled <= lo) begin
            inv = 1'b1;
            r = uns ? 32'h0 : (half ? 32'hFFFF8000 : 32'h80000000);
        end else begin
            q = longint'(scaled);
            if (scaled >= 0.0 && real'(q) > scaled) q = q - 1;
            if (scaled < 0.0 && real'(q) < scaled) q = q + 1;
            r = q[31:0];
            inx = (real'(q) != scaled);
        end
    endtask

    task automatic run(input logic [31:0] f, input int k, input bit uns, input bit half);
        logic [31:0] er;
        bit          ei;
        bit          ex;
        string       tag;
        fp_in = f; frac_bits = k[5:0]; unsigned_sel = uns; half_sel = half; in_valid = 1'b1;
        @(negedge clk);
        model(f, k, uns, half, er, ei, ex);
        if (f[30:23] == 8'hFF && f[22:0] != '0) tag = "R8";
        else if (f[30:23] == 8'h00 && f[22:0] != '0) tag = "R10";
        else if (ei) tag = uns ? "R7" : "R6";
        else if (ex) tag = "R9";
        else if (half) tag = uns ? "R5" : "R4";
        else tag = "R3";
        chk(out_valid == 1'b1, "R2", "out_valid", {31'b0, out_valid}, 32'h1);
        chk(fx_out == er, tag, "fx_out", fx_out, er);
        chk(flag_invalid == ei, tag, "invalid", {31'b0, flag_invalid}, {31'b0, ei});
        chk(flag_inexact == ex, tag, "inexact", {31'b0, flag_inexact}, {31'b0, ex});
    endtask

    initial begin
        logic [22:0] mans [5];
        int          fbl  [5];
        logic [31:0] held;
        mans = '{23'h0, 23'h1, 23'h400000, 23'h7FFFFF, 23'h2AAAAA};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid", {31'b0, out_valid}, 32'h0);
        chk(fx_out == 32'h0, "R1", "fx_out", fx_out, 32'h0);
        chk(!flag_invalid && !flag_inexact, "R1", "flags",
            {30'b0, flag_invalid, flag_inexact}, 32'h0);
        rst = 1'b0;

        // directed: 1.5 with k=1 gives 3 (R3); -2.75 k=2 signed 16 gives -11 (R4)
        run(32'h3FC00000, 1, 1'b0, 1'b0);
        run(32'hC0300000, 2, 1'b0, 1'b1);
        chk(fx_out == 32'hFFFFFFF5, "R4", "neg half", fx_out, 32'hFFFFFFF5);
        // -0.5 unsigned gives 0 inexact only (R7)
        run(32'hBF000000, 0, 1'b1, 1'b0);
        chk(!flag_invalid && flag_inexact, "R7", "neg frac flags",
            {30'b0, flag_invalid, flag_inexact}, 32'h1);

        // R2: hold while idle
        held = fx_out;
        in_valid = 1'b0; fp_in = 32'h47000000;
        @(negedge clk);
        chk(out_valid == 1'b0, "R2", "idle out_valid", {31'b0, out_valid}, 32'h0);
        chk(fx_out == held, "R2", "idle hold", fx_out, held);
        @(negedge clk);
        chk(fx_out == held, "R2", "idle hold 2", fx_out, held);

        // sweep
        for (int e = 0; e < 256; e++) begin
            if (!(e <= 2 || (e >= 110 && e <= 165) || e >= 254)) continue;
            for (int mi = 0; mi < 5; mi++)
                for (int s = 0; s < 2; s++)
                    for (int h = 0; h < 2; h++)
                        for (int u = 0; u < 2; u++) begin
                            fbl = '{0, 1, 5, (h != 0 ? 15 : 31), (h != 0 ? 16 : 32)};
                            for (int fi = 0; fi < 5; fi++)
                                run({s[0], e[7:0], mans[mi]}, fbl[fi], u[0], h[0]);
                        end
        end

        // R1: reset after activity
        run(32'h3FC00000, 1, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && fx_out == 32'h0, "R1", "reset clears",
            fx_out, 32'h0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && fx_out == 32'h0 && !flag_invalid && !flag_inexact,
            "R1", "after reset", fx_out, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule